// File: doc/BRIEF.md
# Memory-Mapping Mode Flag Register

This block keeps the five mode flags that steer memory mapping in an 8-bit computer with auxiliary memory. The flags are auxiliary-RAM read select, auxiliary-RAM write select, internal slot-ROM override, alternate zero page, and slot-3 card ROM enable. Software changes a flag by writing to one of a pair of addresses in the low I/O page. The even address of the pair clears the flag and the odd address sets it. The data written does not matter.

Each flag also has a status address. A read there returns the flag in the top data bit. Two more status addresses pass through the language-card bank-2 select and RAM-read enable. Those two signals come from a separate language-card controller, and this block does not decode the language-card switches. Flag outputs feed the address router directly. A status read is answered one clock after the read strobe, together with a valid flag.

Top module: `mode_switch_regs`

## Requirements
- R1: After a synchronous active-low reset, all five flag outputs are 0 and `stat_valid` is 0.
- R2: Flag index i (0 aux_read, 1 aux_write, 2 int_slot_rom, 3 alt_zpage, 4 slot3_card_rom) is cleared by a write strobe with address 0x02+2i and set by a write strobe with address 0x03+2i. The flag output shows the new value in the cycle after the strobe.
- R3: A write strobe to any address outside 0x02..0x0B leaves every flag unchanged. This includes the status addresses 0x11..0x17.
- R4: A read strobe at 0x13+i gives, in the next cycle, `stat_valid`=1, `stat_data[7]` equal to flag i, and `stat_data[6:0]`=0.
- R5: A read strobe at 0x11 returns `lc_bank2` in bit 7, and a read strobe at 0x12 returns `lc_ram_read` in bit 7. Bits 6:0 are 0 and `stat_valid` is 1 in the next cycle.
- R6: A read strobe at any other address gives `stat_valid`=0 and `stat_data`=0 in the next cycle.
- R7: A read strobe never changes a flag, even at a set or clear address.
- R8: A write that targets one flag leaves the other four flags unchanged.
- R9: In a cycle after one with no read strobe, `stat_valid` is 0 and `stat_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 8 | Low byte of the I/O address |
| io_wr | input | 1 | Write strobe, one cycle |
| io_rd | input | 1 | Read strobe, one cycle |
| lc_bank2 | input | 1 | Language-card bank 2 selected (from the LC controller) |
| lc_ram_read | input | 1 | Language-card RAM read enabled (from the LC controller) |
| stat_data | output | 8 | Status read data, flag in bit 7 |
| stat_valid | output | 1 | Status read hit on the previous cycle |
| aux_read | output | 1 | Auxiliary RAM read select |
| aux_write | output | 1 | Auxiliary RAM write select |
| int_slot_rom | output | 1 | Internal ROM overrides all slot ROM |
| alt_zpage | output | 1 | Alternate zero page and stack |
| slot3_card_rom | output | 1 | Slot 3 served by the card ROM rather than internal ROM |

## Verification
Each flag is first set and then cleared on its own while the other four are watched. This shows whether the decoder has swapped addresses between flags or mixed up the even and odd halves of a pair. Writes then go to neighbouring addresses (0x00, 0x01, 0x0C, 0x11, 0x17, 0xFF) while all flags are set, which exposes a decode range that is too wide. Reads at set and clear addresses confirm that the read strobe cannot toggle a flag. Status reads are made with the flags and the two language-card inputs in alternating patterns. This separates a correct status map from one that is shifted by an address or places the bit in the wrong position.

// File: rtl/mode_switch_pkg.sv
// Shared constants for the mode flag register.
// Assumes: 8-bit I/O address byte, flags indexed in set/clear pair order.
package mode_switch_pkg;
    localparam int NUM_FLAGS   = 5;     // mode flags held by the block
    localparam int ADDR_W      = 8;     // low I/O address byte
    localparam int DATA_W      = 8;     // status data width
    localparam int CLR_BASE    = 'h02;  // clear address of flag 0; set is +1
    localparam int STAT_BASE   = 'h13;  // status address of flag 0
    localparam int LC_BANK_ADR = 'h11;  // status of language-card bank 2
    localparam int LC_READ_ADR = 'h12;  // status of language-card RAM read
    localparam int PAIR_END    = CLR_BASE + 2 * NUM_FLAGS; // first address past the pairs

    typedef enum logic [2:0] {
        F_AUX_READ  = 3'd0,
        F_AUX_WRITE = 3'd1,
        F_INT_SLOT  = 3'd2,
        F_ALT_ZP    = 3'd3,
        F_SLOT3     = 3'd4
    } flag_idx_e;
endpackage

// File: rtl/mode_switch_decode.sv
// Write decoder: turns a write strobe plus address into one-hot set/clear
// pulses, one pair per flag. Assumes pair i sits at CLR_BASE+2i / +2i+1.
module mode_switch_decode
    import mode_switch_pkg::*;
#(
    parameter int N = NUM_FLAGS
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    output logic [N-1:0]      set_p,
    output logic [N-1:0]      clr_p
);
    for (genvar i = 0; i < N; i++) begin : g_pair
        localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(CLR_BASE + 2 * i);
        localparam logic [ADDR_W-1:0] SET_A = ADDR_W'(CLR_BASE + 2 * i + 1);
        // match this flag's clear and set addresses
        always_comb begin
            clr_p[i] = wr && (addr == CLR_A);
            set_p[i] = wr && (addr == SET_A);
        end
    end
endmodule

// File: rtl/mode_switch_flags.sv
// Flag storage: one register per flag, updated by set/clear pulses.
// Assumes set and clear for the same flag never arrive together.
module mode_switch_flags
    import mode_switch_pkg::*;
#(
    parameter int N = NUM_FLAGS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_p,
    input  logic [N-1:0] clr_p,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        // hold, set or clear flag i
        always_ff @(posedge clk) begin
            if (!rst_n)        q[i] <= 1'b0;
            else if (set_p[i]) q[i] <= 1'b1;
            else if (clr_p[i]) q[i] <= 1'b0;
        end

        // R2
        set_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set_p[i] |=> q[i]);
        // R2
        clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_p[i] && !set_p[i]) |=> !q[i]);
        // R8
        idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!set_p[i] && !clr_p[i]) |=> $stable(q[i]));
    end
endmodule

// File: rtl/mode_switch_status.sv
// Status read port: maps the read address to one status bit and registers
// it with a valid flag. Unlisted addresses return zero with valid low.
module mode_switch_status
    import mode_switch_pkg::*;
#(
    parameter int N = NUM_FLAGS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic [N-1:0]      flags,
    input  logic              lc_bank2,
    input  logic              lc_ram_read,
    output logic [DATA_W-1:0] data,
    output logic              valid
);
    logic hit;
    logic bit_val;

    // select the status bit addressed by this read
    always_comb begin
        hit     = 1'b0;
        bit_val = 1'b0;
        if (addr == ADDR_W'(LC_BANK_ADR)) begin
            hit = 1'b1; bit_val = lc_bank2;
        end else if (addr == ADDR_W'(LC_READ_ADR)) begin
            hit = 1'b1; bit_val = lc_ram_read;
        end
        for (int i = 0; i < N; i++) begin
            if (addr == ADDR_W'(STAT_BASE + i)) begin
                hit = 1'b1; bit_val = flags[i];
            end
        end
    end

    // register the response one cycle after the read strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            data  <= '0;
        end else begin
            valid <= rd && hit;
            data  <= {(rd && hit && bit_val), {(DATA_W-1){1'b0}}};
        end
    end

    // R9
    no_rd_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> (!valid && data == '0));
    // R4
    low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data[DATA_W-2:0] == '0);
    // R6
    miss_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> data == '0);
endmodule

// File: rtl/mode_switch_regs.sv
// Top of the memory-mapping mode flag register: write decode, flag storage
// and status read port. Assumes single-cycle strobes on a shared address.
module mode_switch_regs
    import mode_switch_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic              lc_bank2,
    input  logic              lc_ram_read,
    output logic [DATA_W-1:0] stat_data,
    output logic              stat_valid,
    output logic              aux_read,
    output logic              aux_write,
    output logic              int_slot_rom,
    output logic              alt_zpage,
    output logic              slot3_card_rom
);
    logic [NUM_FLAGS-1:0] set_p, clr_p, flags;

    mode_switch_decode #(.N(NUM_FLAGS)) u_decode (
        .addr(io_addr), .wr(io_wr), .set_p(set_p), .clr_p(clr_p)
    );

    mode_switch_flags #(.N(NUM_FLAGS)) u_flags (
        .clk(clk), .rst_n(rst_n), .set_p(set_p), .clr_p(clr_p), .q(flags)
    );

    mode_switch_status #(.N(NUM_FLAGS)) u_status (
        .clk(clk), .rst_n(rst_n), .addr(io_addr), .rd(io_rd),
        .flags(flags), .lc_bank2(lc_bank2), .lc_ram_read(lc_ram_read),
        .data(stat_data), .valid(stat_valid)
    );

    // fan the flag vector out to named outputs
    always_comb begin
        aux_read       = flags[F_AUX_READ];
        aux_write      = flags[F_AUX_WRITE];
        int_slot_rom   = flags[F_INT_SLOT];
        alt_zpage      = flags[F_ALT_ZP];
        slot3_card_rom = flags[F_SLOT3];
    end

    // R3
    outside_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && !(io_addr >= ADDR_W'(CLR_BASE) && io_addr < ADDR_W'(PAIR_END)))
            |=> $stable(flags));
    // R7
    read_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && !io_wr) |=> $stable(flags));
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (flags == '0 && !stat_valid));
endmodule

// File: tb/mode_switch_regs_tb.sv
module mode_switch_regs_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] io_addr = 8'h00;
    logic       io_wr = 1'b0, io_rd = 1'b0;
    logic       lc_bank2 = 1'b0, lc_ram_read = 1'b0;
    logic [7:0] stat_data;
    logic       stat_valid;
    logic       aux_read, aux_write, int_slot_rom, alt_zpage, slot3_card_rom;

    int n_chk = 0, n_bad = 0;
    logic [4:0] exp_f = '0;

    always #10 clk = ~clk; // 50 MHz

    mode_switch_regs u_dut (
        .clk, .rst_n, .io_addr, .io_wr, .io_rd, .lc_bank2, .lc_ram_read,
        .stat_data, .stat_valid, .aux_read, .aux_write, .int_slot_rom,
        .alt_zpage, .slot3_card_rom
    );

    function automatic logic [4:0] flags_now();
        return {slot3_card_rom, alt_zpage, int_slot_rom, aux_write, aux_read};
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one strobe for a cycle; sample at the following falling edge
    task automatic strobe(input logic [7:0] a, input logic w, input logic r);
        @(negedge clk);
        io_addr = a; io_wr = w; io_rd = r;
        @(negedge clk);
        io_wr = 1'b0; io_rd = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 flags", {11'd0, flags_now()}, 16'd0);
        check("R1 valid", {15'd0, stat_valid}, 16'd0);
    endtask

    task automatic t_each_flag();
        for (int i = 0; i < 5; i++) begin
            strobe(8'(3 + 2 * i), 1'b1, 1'b0);
            exp_f[i] = 1'b1;
            check("R2 set/R8 others", {11'd0, flags_now()}, {11'd0, exp_f});
        end
        for (int i = 4; i >= 0; i--) begin
            strobe(8'(2 + 2 * i), 1'b1, 1'b0);
            exp_f[i] = 1'b0;
            check("R2 clr/R8 others", {11'd0, flags_now()}, {11'd0, exp_f});
        end
        strobe(8'h07, 1'b1, 1'b0); exp_f[2] = 1'b1;
        strobe(8'h07, 1'b1, 1'b0);
        check("R2 set twice", {11'd0, flags_now()}, {11'd0, exp_f});
    endtask

    task automatic t_ignored_writes();
        logic [7:0] bad [6] = '{8'h00, 8'h01, 8'h0C, 8'h11, 8'h17, 8'hFF};
        for (int i = 0; i < 5; i++) strobe(8'(3 + 2 * i), 1'b1, 1'b0);
        exp_f = 5'h1F;
        for (int k = 0; k < 6; k++) begin
            strobe(bad[k], 1'b1, 1'b0);
            check("R3 outside write", {11'd0, flags_now()}, {11'd0, exp_f});
        end
        strobe(8'h0A, 1'b1, 1'b0); exp_f[4] = 1'b0;
        strobe(8'h0C, 1'b1, 1'b0);
        check("R3 after 0x0C", {11'd0, flags_now()}, {11'd0, exp_f});
    endtask

    task automatic t_reads_inert();
        strobe(8'h02, 1'b0, 1'b1);
        strobe(8'h0B, 1'b0, 1'b1);
        check("R7 read no effect", {11'd0, flags_now()}, {11'd0, exp_f});
        check("R6 read of pair addr", {7'd0, stat_valid, stat_data}, 16'd0);
    endtask

    task automatic t_status(input logic [4:0] pat);
        for (int i = 0; i < 5; i++)
            strobe(8'(pat[i] ? 3 + 2 * i : 2 + 2 * i), 1'b1, 1'b0);
        exp_f = pat;
        for (int i = 0; i < 5; i++) begin
            strobe(8'(8'h13 + i), 1'b0, 1'b1);
            check("R4 status", {7'd0, stat_valid, stat_data}, {7'd0, 1'b1, exp_f[i], 7'd0});
        end
    endtask

    task automatic t_lc(input logic b2, input logic rr);
        lc_bank2 = b2; lc_ram_read = rr;
        strobe(8'h11, 1'b0, 1'b1);
        check("R5 bank2", {7'd0, stat_valid, stat_data}, {7'd0, 1'b1, b2, 7'd0});
        strobe(8'h12, 1'b0, 1'b1);
        check("R5 ram read", {7'd0, stat_valid, stat_data}, {7'd0, 1'b1, rr, 7'd0});
    endtask

    task automatic t_unlisted();
        logic [7:0] miss [4] = '{8'h10, 8'h18, 8'h01, 8'h93};
        lc_bank2 = 1'b1;
        for (int k = 0; k < 4; k++) begin
            strobe(miss[k], 1'b0, 1'b1);
            check("R6 unlisted read", {7'd0, stat_valid, stat_data}, 16'd0);
        end
        strobe(8'h11, 1'b0, 1'b1);
        @(negedge clk);
        check("R9 idle cycle", {7'd0, stat_valid, stat_data}, 16'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reset();
        t_each_flag();
        t_ignored_writes();
        t_reads_inert();
        t_status(5'b10101);
        t_status(5'b01010);
        t_lc(1'b1, 1'b0);
        t_lc(1'b0, 1'b1);
        t_unlisted();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 re-reset", {11'd0, flags_now()}, 16'd0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule